// File: doc/BRIEF.md
# Signal Pulse and Event Watchdog

This block watches one single-bit signal that is already synchronous to the block clock and raises a sticky error flag when the signal misbehaves. It runs in one of two modes. In event mode, a chosen kind of activity (an edge or a level) must appear at least once in every window of a programmed number of cycles. In pulse mode, each pulse of the chosen polarity is measured in clock cycles and judged against a programmed lower and upper bound. The judgement is either "the width must fall inside the bounds" or "the width must fall outside them".

Software sets the block up through a small write-only register port. It then raises `enable` and later reads `err_flag`. A one-cycle `err_clr` pulse clears the flag. The block has no data stream, so every pin is a plain control or status pin.

Top module: `sig_watchdog`

## Requirements
- R1: After reset `err_flag` is 0 and every configuration register is 0. A zero control word selects event mode with the rising-edge kind, and a zero window leaves event checking idle.
- R2: A write with `cfg_we` high updates one register at the next clock edge, chosen by `cfg_addr`: 0 is the control word, 1 is the event window, 2 is the pulse lower bound and 3 is the pulse upper bound. Control word fields: bit 0 selects the mode (0 event, 1 pulse), bit 1 the policy (0 inside required, 1 outside required), bit 2 the polarity (0 high pulse, 1 low pulse), and bits 5:3 the event kind.
- R3: In event mode with window W > 0, if W enabled clock edges in a row pass without the qualifying activity, `err_flag` is 1 after the W-th such edge. The count then restarts. A window of 0 never raises an error.
- R4: Event kinds: 0 is a rising edge, 1 a falling edge, 2 either edge, 3 the signal high, and 4 the signal low. Any qualifying cycle restarts the window count. Codes 5 to 7 never qualify.
- R5: In pulse mode the width is the number of clock edges at which the signal was sampled at the active level, from the opening edge to the closing edge. The verdict is taken at the closing edge, and `err_flag` shows it right after that edge.
- R6: With policy 0, a pulse is an error when its width is below the lower bound or above the upper bound. Both bounds are themselves allowed.
- R7: With policy 1, a pulse is an error when its width lies between the bounds, both included.
- R8: Polarity 1 measures low pulses, opened by a falling edge and closed by a rising edge. Polarity 0 measures high pulses.
- R9: The width counter saturates at its all-ones value, so an overlong pulse is judged as the longest width and never wraps.
- R10: `err_flag` stays set until an `err_clr` cycle. If a violation and `err_clr` fall in the same cycle, the flag stays set.
- R11: While `enable` is low, all counters stay at zero and no error is raised. A pulse that is already in progress when `enable` rises is not measured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the selected check; low holds counters at zero |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | CNT_W | Configuration write data |
| mon_in | input | 1 | Monitored signal, synchronous to clk |
| err_clr | input | 1 | Clears the sticky error flag |
| err_flag | output | 1 | Sticky violation flag |

## Verification
The bench goes after off-by-one errors at the window and at the bounds. It checks the exact cycle in which an event window expires, and it checks pulses one cycle either side of each bound, where a design with a wrong comparison would flag a legal width or pass an illegal one. A pulse longer than the counter range must still be flagged, because a wrapping counter would fold it back into the legal band. The bench also drives a violation in the same cycle as a clear, which a clear-first design would lose, and a pulse that is already in progress when `enable` rises, which a design tracking levels rather than edges would wrongly measure.

// File: rtl/sig_wdog_pkg.sv
package sig_wdog_pkg;

  // Event kinds selectable in event mode
  typedef enum logic [2:0] {
    EV_RISE   = 3'd0,
    EV_FALL   = 3'd1,
    EV_TOGGLE = 3'd2,
    EV_HIGH   = 3'd3,
    EV_LOW    = 3'd4
  } ev_kind_e;

  // Configuration register select
  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_WIN  = 2'd1,
    A_MIN  = 2'd2,
    A_MAX  = 2'd3
  } cfg_addr_e;

  // Control word, LSB first: mode, policy, polarity, kind
  typedef struct packed {
    logic [2:0] ev_kind;    // bits 5:3
    logic       neg_pol;    // bit 2
    logic       outside;    // bit 1
    logic       pulse_mode; // bit 0
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/swd_cfg_regs.sv
module swd_cfg_regs
  import sig_wdog_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output ctrl_t            ctrl,
  output logic [CNT_W-1:0] win,
  output logic [CNT_W-1:0] lo_bound,
  output logic [CNT_W-1:0] hi_bound
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      win      <= '0;
      lo_bound <= '0;
      hi_bound <= '0;
    end else if (we) begin
      case (cfg_addr_e'(addr))
        A_CTRL:  ctrl     <= ctrl_t'(wdata[CTRL_W-1:0]);
        A_WIN:   win      <= wdata;
        A_MIN:   lo_bound <= wdata;
        default: hi_bound <= wdata;
      endcase
    end
  end

endmodule

// File: rtl/swd_edge_det.sv
module swd_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic rise,
  output logic fall
);

  logic sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig;
  end

  assign rise = sig & ~sig_q;
  assign fall = ~sig & sig_q;

endmodule

// File: rtl/swd_event_chk.sv
module swd_event_chk
  import sig_wdog_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [2:0]       kind,
  input  logic [CNT_W-1:0] win,
  input  logic             sig,
  input  logic             rise,
  input  logic             fall,
  output logic             viol,
  output logic [CNT_W-1:0] cnt
);

  logic qual;

  always_comb begin
    case (kind)
      EV_RISE:   qual = rise;
      EV_FALL:   qual = fall;
      EV_TOGGLE: qual = rise | fall;
      EV_HIGH:   qual = sig;
      EV_LOW:    qual = ~sig;
      default:   qual = 1'b0;
    endcase
  end

  assign viol = run && !qual && (win != '0) && (cnt == win - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  cnt <= '0;
    else if (!run || qual || viol || win == '0)  cnt <= '0;
    else                                         cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/swd_pulse_chk.sv
module swd_pulse_chk #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             neg_pol,
  input  logic             outside,
  input  logic [CNT_W-1:0] lo_bound,
  input  logic [CNT_W-1:0] hi_bound,
  input  logic             rise,
  input  logic             fall,
  output logic             viol,
  output logic             active,
  output logic [CNT_W-1:0] width
);

  localparam logic [CNT_W-1:0] SAT = '1;

  logic open_e, close_e, in_band;

  assign open_e  = neg_pol ? fall : rise;
  assign close_e = neg_pol ? rise : fall;
  assign in_band = (width >= lo_bound) && (width <= hi_bound);
  assign viol    = run && active && close_e && (outside ? in_band : !in_band);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      width  <= '0;
    end else if (!run) begin
      active <= 1'b0;
      width  <= '0;
    end else if (open_e) begin
      active <= 1'b1;
      width  <= {{(CNT_W-1){1'b0}}, 1'b1};
    end else if (close_e) begin
      active <= 1'b0;
      width  <= '0;
    end else if (active && width != SAT) begin
      width  <= width + 1'b1;
    end
  end

endmodule

// File: rtl/sig_watchdog.sv
module sig_watchdog
  import sig_wdog_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [CNT_W-1:0] cfg_wdata,
  input  logic             mon_in,
  input  logic             err_clr,
  output logic             err_flag
);

  ctrl_t            ctrl;
  logic [CNT_W-1:0] win, lo_bound, hi_bound;
  logic             rise, fall;
  logic             ev_viol, pw_viol, viol;
  logic [CNT_W-1:0] ev_cnt, pw_cnt;
  logic             pw_active;

  swd_cfg_regs #(.CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .ctrl     (ctrl),
    .win      (win),
    .lo_bound (lo_bound),
    .hi_bound (hi_bound)
  );

  swd_edge_det u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .sig   (mon_in),
    .rise  (rise),
    .fall  (fall)
  );

  swd_event_chk #(.CNT_W(CNT_W)) u_event (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (enable && !ctrl.pulse_mode),
    .kind  (ctrl.ev_kind),
    .win   (win),
    .sig   (mon_in),
    .rise  (rise),
    .fall  (fall),
    .viol  (ev_viol),
    .cnt   (ev_cnt)
  );

  swd_pulse_chk #(.CNT_W(CNT_W)) u_pulse (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (enable && ctrl.pulse_mode),
    .neg_pol  (ctrl.neg_pol),
    .outside  (ctrl.outside),
    .lo_bound (lo_bound),
    .hi_bound (hi_bound),
    .rise     (rise),
    .fall     (fall),
    .viol     (pw_viol),
    .active   (pw_active),
    .width    (pw_cnt)
  );

  assign viol = ev_viol | pw_viol;

  // Sticky flag; a new violation wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_flag <= 1'b0;
    else if (viol)    err_flag <= 1'b1;
    else if (err_clr) err_flag <= 1'b0;
  end

endmodule

// File: rtl/sig_watchdog_chk.sv
module sig_watchdog_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             err_clr,
  input logic             err_flag,
  input logic             viol,
  input logic [CNT_W-1:0] ev_cnt,
  input logic [CNT_W-1:0] pw_cnt,
  input logic             pw_active
);

  p_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> err_flag);

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> err_flag);

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !viol) |=> !err_flag);

  p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (ev_cnt == '0 && pw_cnt == '0 && !pw_active));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !err_clr) |=> $stable(err_flag));

  p_saturate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && pw_cnt == '1) |=> (pw_cnt == '1 || pw_cnt == '0));

endmodule

bind sig_watchdog sig_watchdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .err_clr   (err_clr),
  .err_flag  (err_flag),
  .viol      (viol),
  .ev_cnt    (ev_cnt),
  .pw_cnt    (pw_cnt),
  .pw_active (pw_active)
);

// File: tb/test_sig_watchdog.sv
module test_sig_watchdog;

  localparam int CW = 8;
  localparam int NV = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_addr = '0;
  logic [CW-1:0] cfg_wdata = '0;
  logic          mon_in = 1'b0;
  logic          err_clr = 1'b0;
  logic          err_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  sig_watchdog #(.CNT_W(CW)) i_sig_watchdog (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .mon_in    (mon_in),
    .err_clr   (err_clr),
    .err_flag  (err_flag)
  );

  // Pulse vectors: policy, polarity, bounds, width, expected flag
  typedef struct packed {
    logic       outside;
    logic       neg;
    logic [7:0] mn;
    logic [7:0] mx;
    logic [8:0] w;
    logic       exp;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 8'd5,  8'd10,  9'd5,   1'b0},
    '{1'b0, 1'b0, 8'd5,  8'd10,  9'd4,   1'b1},
    '{1'b0, 1'b0, 8'd5,  8'd10,  9'd10,  1'b0},
    '{1'b0, 1'b0, 8'd5,  8'd10,  9'd11,  1'b1},
    '{1'b0, 1'b1, 8'd5,  8'd10,  9'd7,   1'b0},
    '{1'b0, 1'b1, 8'd5,  8'd10,  9'd3,   1'b1},
    '{1'b1, 1'b0, 8'd5,  8'd10,  9'd5,   1'b1},
    '{1'b1, 1'b0, 8'd5,  8'd10,  9'd10,  1'b1},
    '{1'b1, 1'b0, 8'd5,  8'd10,  9'd4,   1'b0},
    '{1'b1, 1'b0, 8'd5,  8'd10,  9'd11,  1'b0},
    '{1'b1, 1'b1, 8'd5,  8'd10,  9'd8,   1'b1},
    '{1'b0, 1'b0, 8'd10, 8'd200, 9'd200, 1'b0}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: err_flag=%0b expected %0b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [CW-1:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    step(1);
    cfg_we = 1'b0;
  endtask

  function automatic logic [CW-1:0] ctrl_word(input logic pulse, input logic outside,
                                              input logic neg, input logic [2:0] kind);
    return {2'b00, kind, neg, outside, pulse};
  endfunction

  task automatic clear_err();
    err_clr = 1'b1;
    step(1);
    err_clr = 1'b0;
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R1 reset flag", err_flag, 1'b0);

    // Table of pulse vectors (R2 control fields, R5 width, R6/R7/R8)
    for (int i = 0; i < NV; i++) begin
      enable = 1'b0;
      mon_in = VECS[i].neg;
      wr(2'd0, ctrl_word(1'b1, VECS[i].outside, VECS[i].neg, 3'd0));
      wr(2'd2, VECS[i].mn);
      wr(2'd3, VECS[i].mx);
      clear_err();
      enable = 1'b1;
      step(2);
      mon_in = ~VECS[i].neg;
      step(int'(VECS[i].w));
      mon_in = VECS[i].neg;
      step(1);
      if (VECS[i].outside)  chk("R7 outside policy (R5 width)", err_flag, VECS[i].exp);
      else if (VECS[i].neg) chk("R8 low pulse (R5 width)", err_flag, VECS[i].exp);
      else                  chk("R6 inside policy (R5 width)", err_flag, VECS[i].exp);
    end

    // R3: exact window expiry, rising-edge kind, window 6
    enable = 1'b0; mon_in = 1'b0;
    wr(2'd0, ctrl_word(1'b0, 1'b0, 1'b0, 3'd0));
    wr(2'd1, 8'd6);
    clear_err();
    enable = 1'b1;
    step(5);
    chk("R3 no error before window end", err_flag, 1'b0);
    step(1);
    chk("R3 error at window end (R2 window write)", err_flag, 1'b1);

    // R10: violation coinciding with clear keeps the flag; a later clear drops it
    step(5);
    err_clr = 1'b1;
    step(1);
    chk("R10 set wins over clear", err_flag, 1'b1);
    step(1);
    chk("R10 clear", err_flag, 1'b0);
    err_clr = 1'b0;

    // R4: rising edges every 4 cycles keep the window alive
    enable = 1'b0; step(1); enable = 1'b1;
    for (int k = 0; k < 5; k++) begin
      mon_in = 1'b1; step(1); mon_in = 1'b0; step(3);
    end
    chk("R4 rise kind restarts window", err_flag, 1'b0);
    step(6);
    chk("R4 rise kind expiry after activity stops", err_flag, 1'b1);

    // R4: falling-edge kind
    enable = 1'b0; clear_err();
    wr(2'd0, ctrl_word(1'b0, 1'b0, 1'b0, 3'd1));
    enable = 1'b1;
    for (int k = 0; k < 5; k++) begin
      mon_in = 1'b1; step(2); mon_in = 1'b0; step(2);
    end
    chk("R4 fall kind restarts window", err_flag, 1'b0);
    mon_in = 1'b1;
    step(8);
    chk("R4 fall kind expiry", err_flag, 1'b1);

    // R4: high level qualifies, low level does not while signal is high
    enable = 1'b0; clear_err();
    wr(2'd0, ctrl_word(1'b0, 1'b0, 1'b0, 3'd3));
    mon_in = 1'b1;
    enable = 1'b1;
    step(20);
    chk("R4 high level holds window", err_flag, 1'b0);
    wr(2'd0, ctrl_word(1'b0, 1'b0, 1'b0, 3'd4));
    step(7);
    chk("R4 low level expiry", err_flag, 1'b1);

    // R3: window 0 never fires
    enable = 1'b0; clear_err();
    wr(2'd1, 8'd0);
    wr(2'd0, ctrl_word(1'b0, 1'b0, 1'b0, 3'd0));
    mon_in = 1'b0;
    enable = 1'b1;
    step(30);
    chk("R3 zero window idle", err_flag, 1'b0);

    // R11: disabled block raises nothing
    enable = 1'b0;
    wr(2'd1, 8'd3);
    clear_err();
    step(20);
    chk("R11 disabled no error", err_flag, 1'b0);

    // R11: pulse already active at enable is not measured
    wr(2'd0, ctrl_word(1'b1, 1'b0, 1'b0, 3'd0));
    wr(2'd2, 8'd5);
    wr(2'd3, 8'd10);
    mon_in = 1'b1;
    clear_err();
    enable = 1'b1;
    step(20);
    mon_in = 1'b0;
    step(2);
    chk("R11 pulse in progress at enable ignored", err_flag, 1'b0);

    // R9: overlong pulse saturates, not wraps into the legal band
    enable = 1'b0;
    wr(2'd2, 8'd10);
    wr(2'd3, 8'd200);
    clear_err();
    enable = 1'b1;
    step(2);
    mon_in = 1'b1;
    step(300);
    mon_in = 1'b0;
    step(1);
    chk("R9 saturated width flagged", err_flag, 1'b1);

    // R10: flag sticky through disable and signal activity
    enable = 1'b0;
    for (int k = 0; k < 3; k++) begin
      mon_in = 1'b1; step(2); mon_in = 1'b0; step(2);
    end
    chk("R10 sticky while disabled", err_flag, 1'b1);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, got hung, expected completion");
      summary();
      $finish;
    end
  end

endmodule